// File: doc/BRIEF.md
# Enabled Push/Pop Stack With Registered Output

This block is a last-in, first-out store of eight 8-bit entries driven by three controls: an enable, a push request and a pop request, with one write-data bus. In a cycle with the enable low the block is frozen. In an enabled cycle at most one operation happens. Push takes priority over pop. A push into a full stack is dropped, and a pop from an empty stack is dropped.

The output is registered with a one-enabled-cycle lag. An internal next-output register holds the top of stack as it stood after the latest enabled operation. On each enabled cycle the output takes the old contents of that register, and the register then loads the new top. When an operation leaves the stack empty, the next-output register keeps its value. A consumer therefore sees each top-of-stack value one enabled cycle after it is formed.

Top module: `lifo_regout`

## Requirements
- R1: After reset the stack is empty, and both the output and the next-output register are 0.
- R2: In a cycle with en low, nothing changes: dout, the stored entries and the entry count stay as they were, whatever push, pop and din carry.
- R3: With en high, push high and fewer than DEPTH (8) entries held, din is written as the new top entry and the count rises by one.
- R4: With en high and push high while DEPTH entries are held, the push is dropped and pop is not acted on either, so the contents and the count are unchanged.
- R5: With en high, push low and pop high, the top entry is removed if the stack is not empty. A pop on an empty stack has no effect.
- R6: With en high and both push and pop high while the stack has room, only the push takes effect.
- R7: In every enabled cycle dout takes the value held in the next-output register before that edge. That register then loads the top entry left by the operation, if the stack is not empty.
- R8: If the stack is empty after an enabled operation, the next-output register keeps its previous value. The next enabled cycle therefore shows that value again on dout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enables one operation this cycle |
| push | input | 1 | Push request; wins over pop |
| pop | input | 1 | Pop request |
| din | input | WIDTH | Data written on a push |
| dout | output | WIDTH | Registered output, lagging the top of stack by one enabled cycle |

## Verification
The in-RTL assertions check on every cycle that a disabled cycle leaves the output and the count untouched. They also check that the count never exceeds the depth, that a push into a full stack leaves the count unchanged, that an accepted push raises the count by one, and that each enabled cycle moves the previous next-output value onto dout. The stored data itself, meaning which entry a pop exposes, the ordering of the stack, the value held over an emptying pop and the effect of push priority on the data, can only be shown by the bench's scenarios. The bench does this by reading the values back through dout, one enabled cycle late.

// File: rtl/lifo_regout.sv
module lifo_regout #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] nxt_q;

  logic             full, empty, do_push, do_pop;
  logic [CW-1:0]    new_cnt;
  logic [AW-1:0]    wr_idx, top_idx;
  logic [WIDTH-1:0] new_top;

  assign full    = (cnt == FULL);
  assign empty   = (cnt == '0);
  assign do_push = en && push && !full;
  assign do_pop  = en && !push && pop && !empty;
  assign new_cnt = do_push ? cnt + 1'b1 : (do_pop ? cnt - 1'b1 : cnt);
  assign wr_idx  = AW'(cnt);
  assign top_idx = AW'(new_cnt - 1'b1);
  assign new_top = do_push ? din : mem[top_idx];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      nxt_q <= '0;
      dout  <= '0;
    end else if (en) begin
      cnt  <= new_cnt;
      dout <= nxt_q;
      if (new_cnt != '0) nxt_q <= new_top;
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dout) && $stable(cnt)));

  a_r3_push_count: assert property (@(posedge clk) disable iff (rst)
    (en && push && cnt < FULL) |=> (cnt == $past(cnt) + 1'b1));

  a_r4_full_drop: assert property (@(posedge clk) disable iff (rst)
    (en && push && full) |=> (cnt == FULL));

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

  a_r7_out_from_next: assert property (@(posedge clk) disable iff (rst)
    en |=> (dout == $past(nxt_q)));
endmodule

// File: tb/sim_lifo_regout.sv
module sim_lifo_regout;
  localparam int DEPTH = 8;
  localparam int WIDTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, push = 1'b0, pop = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;

  int checks = 0;
  int failures = 0;

  logic [WIDTH-1:0] m_s [DEPTH];
  int               m_cnt = 0;
  logic [WIDTH-1:0] m_nxt = '0;
  logic [WIDTH-1:0] m_out = '0;

  // {en, push, pop, din}
  localparam logic [10:0] VEC [0:19] = '{
    {3'b110, 8'h11}, {3'b110, 8'h22}, {3'b010, 8'h99}, {3'b101, 8'h00},
    {3'b111, 8'h33}, {3'b100, 8'h00}, {3'b101, 8'h00}, {3'b101, 8'h00},
    {3'b101, 8'h00}, {3'b101, 8'h00}, {3'b100, 8'h00}, {3'b110, 8'h44},
    {3'b001, 8'h00}, {3'b100, 8'h00}, {3'b110, 8'h55}, {3'b111, 8'h66},
    {3'b101, 8'h00}, {3'b000, 8'h77}, {3'b101, 8'h00}, {3'b101, 8'h00}
  };

  always #10 clk = ~clk;

  lifo_regout #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rst(rst), .en(en), .push(push), .pop(pop), .din(din), .dout(dout)
  );

  task automatic model(input logic e, input logic pu, input logic po, input logic [WIDTH-1:0] d);
    if (e) begin
      m_out = m_nxt;
      if (pu) begin
        if (m_cnt < DEPTH) begin
          m_s[m_cnt] = d;
          m_cnt++;
        end
      end else if (po && m_cnt > 0) begin
        m_cnt--;
      end
      if (m_cnt > 0) m_nxt = m_s[m_cnt-1];
    end
  endtask

  task automatic check(input string tag, input logic [WIDTH-1:0] exp);
    checks++;
    if (dout !== exp) begin
      failures++;
      $display("FAIL %s dout=%h expected=%h", tag, dout, exp);
    end
  endtask

  task automatic step(input logic e, input logic pu, input logic po,
                      input logic [WIDTH-1:0] d, input string tag);
    en = e; push = pu; pop = po; din = d;
    model(e, pu, po, d);
    @(negedge clk);
    check(tag, m_out);
  endtask

  initial begin
    #(20 * 5000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset output", '0);
    // R1: the next-output register is 0 too, seen on the first enabled idle cycle
    step(1'b1, 1'b0, 1'b0, 8'h00, "R1 next-output reset");
    step(1'b1, 1'b0, 1'b0, 8'h00, "R1 next-output still 0");

    for (int i = 0; i < 20; i++)
      step(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0], "R7 vector walk");

    // drain what the walk left
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 8'h00, "R5 drain");

    // R3: fill the stack, then read back in reverse order
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b1, 1'b0, 8'(8'hA0 + i), "R3 fill");
    // R4: push while full, also with pop high: nothing changes
    step(1'b1, 1'b1, 1'b0, 8'hEE, "R4 full push dropped");
    step(1'b1, 1'b1, 1'b1, 8'hEF, "R4 no pop fall-through");
    // R2: disabled cycles with requests do nothing
    step(1'b0, 1'b0, 1'b1, 8'h00, "R2 disabled pop");
    step(1'b0, 1'b1, 1'b0, 8'hCC, "R2 disabled push");
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 1'b1, 8'h00, "R5 pop order");
    // R5: pop on empty; R8: next-output keeps A0 (bottom value)
    step(1'b1, 1'b0, 1'b1, 8'h00, "R5 pop empty");
    step(1'b1, 1'b0, 1'b1, 8'h00, "R8 hold after empty");
    checks++;
    if (m_nxt !== 8'hA0) begin
      failures++;
      $display("FAIL R8 model next=%h expected=a0", m_nxt);
    end
    step(1'b1, 1'b0, 1'b0, 8'h00, "R8 value repeats");
    // R6: push and pop together with room
    step(1'b1, 1'b1, 1'b1, 8'h5A, "R6 push wins");
    step(1'b1, 1'b0, 1'b0, 8'h00, "R6 top is pushed value");
    step(1'b1, 1'b0, 1'b0, 8'h00, "R6 top stays");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule